// File: doc/BRIEF.md
# Lifecycle Key Access and Export Gate

This block stands between a one-time-programmable store of hardware keys and the rest of the chip. It takes the current lifecycle state and a secure-provisioning enable, and from them works out which stored keys a host may read and which it may write. Host accesses that the current state forbids are blocked at this point. A denied read returns zero and records a sticky error. A denied write never reaches the store.

After every reset, and before it accepts any host access, the block runs an export pass. First it pushes a fixed key, built into the hardware, into keyslot 0. It then reads each of the six stored keys in turn and counts the zero bits of each one. It compares that count with the zero-count stored next to the key, and loads the key into its fixed keyslot of the key management unit only when the two agree. A flag for each slot records which slots received a key. A done signal marks the end of the pass, and from then on the store belongs to the host port.

The store holds key `k` (0 to 5) at word addresses `k*16 + 0` to `k*16 + 7`, least significant word first. Its zero-count is the low 9 bits of word `k*16 + 8`. The keys map to slots as follows: unique key = key 0 → slot 1, group key = key 1 → slot 2, the two chip-manufacture keys = keys 2 and 3 → slots 3 and 4, the two device-manufacture keys = keys 4 and 5 → slots 5 and 6. The lifecycle code on `lcs` is 0 for chip manufacture, 1 for device manufacture, 2 for secured and 3 for return-to-vendor.

Top module: `lcm_key_gate`

## Requirements
- R1: With `lcs`=0 and `sp_en`=1, keys 0 to 3 are readable and writable (`key_rd_ok`/`key_wr_ok` bits 0 to 3 set), and keys 4 and 5 are neither readable nor writable.
- R2: With `lcs`=1 and `sp_en`=1, only keys 4 and 5 are readable and writable.
- R3: With `lcs`=3, whatever the value of `sp_en`, all six keys are writable and none is readable.
- R4: With `lcs`=2, or with `lcs` at 0 or 1 and `sp_en`=0, no key is readable or writable.
- R5: A host read is answered on `host_rdata` with `host_rvalid` high in the cycle after the request. An allowed read returns the stored word. A denied read returns zero and sets `acc_err`, which stays set until reset.
- R6: An allowed host write updates the addressed store word. A denied write leaves the store unchanged.
- R7: After reset the block first writes the fixed key to slot 0, then handles keys 0 to 5 in order into slots 1 to 6. Each exported key goes out as eight 32-bit writes with `kmu_word` rising from 0 to 7, least significant word first.
- R8: A stored key is exported only when the number of 0 bits in its 256 bits equals the low 9 bits of its count word. A key that fails the check produces no key-unit write.
- R9: `slot_valid` bit s is set exactly for slot 0 and for each slot whose key was exported. `export_done` rises once all seven slots are handled, and it then stays high together with `host_ready`. Host requests are served only while `host_ready` is high.
- R10: `key_rd_ok` and `key_wr_ok` follow `lcs` and `sp_en` in every cycle, both during the export pass and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restarts the export pass |
| lcs | input | 2 | Lifecycle state code |
| sp_en | input | 1 | Secure-provisioning enable |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 7 | Host word address in the key store |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, zero when denied |
| host_rvalid | output | 1 | Read answer valid |
| host_ready | output | 1 | Host port open (export finished) |
| acc_err | output | 1 | Sticky denied-read flag |
| key_rd_ok | output | 6 | Per-key read permission |
| key_wr_ok | output | 6 | Per-key write permission |
| otp_en | output | 1 | Store access enable |
| otp_we | output | 1 | Store write enable |
| otp_addr | output | 7 | Store word address |
| otp_wdata | output | 32 | Store write data |
| otp_rdata | input | 32 | Store read data, one cycle after `otp_en` |
| kmu_we | output | 1 | Key-unit load strobe |
| kmu_slot | output | 3 | Destination keyslot |
| kmu_word | output | 3 | Word index within the key |
| kmu_data | output | 32 | Key word |
| slot_valid | output | 7 | Per-slot loaded flag |
| export_done | output | 1 | Export pass complete |

## Verification
The assertions assume that `lcs` and `sp_en` are driven to known values whenever reset is released. They also assume that the store answers a read in the cycle after `otp_en` and that it writes only when `otp_we` is high. The bench's store model keeps exactly that one-cycle timing. The bench changes the lifecycle inputs only at falling edges and issues host requests only once `host_ready` is high, so no assertion ever sees a host write arrive during the export pass.

// File: rtl/lcm_gate_pkg.sv
package lcm_gate_pkg;

    typedef enum logic [1:0] {
        LCS_CHIP_MFG = 2'd0,
        LCS_DEV_MFG  = 2'd1,
        LCS_SECURED  = 2'd2,
        LCS_RETURN   = 2'd3
    } lcs_e;

    typedef enum logic [2:0] {
        EX_FIXED = 3'd0,
        EX_READ  = 3'd1,
        EX_CHECK = 3'd2,
        EX_PUSH  = 3'd3,
        EX_DONE  = 3'd4
    } exp_state_e;

    // Keys below the chip-stage count belong to the chip-manufacture group.
    function automatic logic in_chip_group(input int k, input int chip_keys);
        return k < chip_keys;
    endfunction

endpackage

// File: rtl/lcm_perm_decode.sv
module lcm_perm_decode
    import lcm_gate_pkg::*;
#(
    parameter int NUM_KEYS  = 6,
    parameter int CHIP_KEYS = 4
) (
    input  logic [1:0]          lcs,
    input  logic                sp_en,
    output logic [NUM_KEYS-1:0] rd_ok,
    output logic [NUM_KEYS-1:0] wr_ok
);
    lcs_e state;
    assign state = lcs_e'(lcs);

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        logic open_rw;
        always_comb begin
            if (in_chip_group(k, CHIP_KEYS)) begin
                open_rw = sp_en && (state == LCS_CHIP_MFG);
            end else begin
                open_rw = sp_en && (state == LCS_DEV_MFG);
            end
            rd_ok[k] = open_rw;
            wr_ok[k] = open_rw || (state == LCS_RETURN);
        end
    end

endmodule

// File: rtl/lcm_export_seq.sv
module lcm_export_seq
    import lcm_gate_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int KEY_WORDS = 8,
    parameter int NUM_KEYS  = 6,
    parameter int STRIDE_LG = 4,
    parameter int ADDR_W    = 7,
    parameter logic [WORD_W*KEY_WORDS-1:0] FIXED_KEY = '0,
    localparam int KEY_W     = WORD_W * KEY_WORDS,
    localparam int NUM_SLOTS = NUM_KEYS + 1,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int WIX_W     = $clog2(KEY_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 otp_en,
    output logic [ADDR_W-1:0]    otp_addr,
    input  logic [WORD_W-1:0]    otp_rdata,
    output logic                 kmu_we,
    output logic [SLOT_W-1:0]    kmu_slot,
    output logic [WIX_W-1:0]     kmu_word,
    output logic [WORD_W-1:0]    kmu_data,
    output logic [NUM_SLOTS-1:0] slot_valid,
    output logic                 done
);
    localparam int KIX_W = $clog2(NUM_KEYS);
    localparam int CNT_W = $clog2(KEY_WORDS + 2);
    localparam int ZC_W  = $clog2(KEY_W + 1);

    typedef struct packed {
        exp_state_e           st;
        logic [KIX_W-1:0]     key;
        logic [CNT_W-1:0]     cnt;
        logic [KEY_W-1:0]     kbuf;
        logic [ZC_W-1:0]      zc;
        logic [NUM_SLOTS-1:0] valid;
    } seq_t;

    seq_t q, d;
    logic advance;
    logic [ZC_W-1:0] zeros;
    int widx;

    always_comb begin
        d        = q;
        advance  = 1'b0;
        otp_en   = 1'b0;
        otp_addr = ADDR_W'((int'(q.key) << STRIDE_LG) + int'(q.cnt));
        kmu_we   = 1'b0;
        kmu_slot = SLOT_W'(int'(q.key) + 1);
        kmu_word = WIX_W'(q.cnt);
        kmu_data = q.kbuf[int'(WIX_W'(q.cnt))*WORD_W +: WORD_W];
        zeros    = ZC_W'(KEY_W - $countones(q.kbuf));
        widx     = int'(q.cnt) - 1;
        case (q.st)
            EX_FIXED: begin
                kmu_we   = 1'b1;
                kmu_slot = '0;
                kmu_data = FIXED_KEY[int'(WIX_W'(q.cnt))*WORD_W +: WORD_W];
                if (int'(q.cnt) == KEY_WORDS - 1) begin
                    d.valid = q.valid | NUM_SLOTS'(1);
                    d.st    = EX_READ;
                    d.cnt   = '0;
                    d.key   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            EX_READ: begin
                otp_en = (int'(q.cnt) <= KEY_WORDS);
                if (q.cnt != '0) begin
                    if (widx < KEY_WORDS) begin
                        d.kbuf[widx*WORD_W +: WORD_W] = otp_rdata;
                    end else begin
                        d.zc = otp_rdata[ZC_W-1:0];
                    end
                end
                if (int'(q.cnt) == KEY_WORDS + 1) begin
                    d.st = EX_CHECK;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            EX_CHECK: begin
                if (zeros == q.zc) begin
                    d.valid = q.valid | (NUM_SLOTS'(1) << (int'(q.key) + 1));
                    d.st    = EX_PUSH;
                    d.cnt   = '0;
                end else begin
                    advance = 1'b1;
                end
            end
            EX_PUSH: begin
                kmu_we = 1'b1;
                if (int'(q.cnt) == KEY_WORDS - 1) begin
                    advance = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: ;
        endcase
        if (advance) begin
            d.cnt = '0;
            if (int'(q.key) == NUM_KEYS - 1) begin
                d.st = EX_DONE;
            end else begin
                d.key = q.key + 1'b1;
                d.st  = EX_READ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign slot_valid = q.valid;
    assign done       = (q.st == EX_DONE);

endmodule

// File: rtl/lcm_host_port.sv
module lcm_host_port #(
    parameter int WORD_W    = 32,
    parameter int KEY_WORDS = 8,
    parameter int NUM_KEYS  = 6,
    parameter int STRIDE_LG = 4,
    parameter int ADDR_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                host_req,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [NUM_KEYS-1:0] rd_ok,
    input  logic [NUM_KEYS-1:0] wr_ok,
    input  logic [WORD_W-1:0]   otp_rdata,
    output logic                otp_en,
    output logic                otp_we,
    output logic [WORD_W-1:0]   host_rdata,
    output logic                host_rvalid,
    output logic                acc_err
);
    typedef struct packed {
        logic rvalid;
        logic pass;
        logic err;
    } hp_t;

    hp_t q, d;
    logic go, r_ok, w_ok, in_range;
    int kidx, widx;

    always_comb begin
        kidx     = int'(host_addr >> STRIDE_LG);
        widx     = int'(host_addr[STRIDE_LG-1:0]);
        in_range = (kidx < NUM_KEYS) && (widx <= KEY_WORDS);
        r_ok     = 1'b0;
        w_ok     = 1'b0;
        for (int k = 0; k < NUM_KEYS; k++) begin
            if (in_range && kidx == k) begin
                r_ok = rd_ok[k];
                w_ok = wr_ok[k];
            end
        end
        go       = active && host_req;
        otp_en   = go && (host_we ? w_ok : r_ok);
        otp_we   = go && host_we && w_ok;
        d.rvalid = go && !host_we;
        d.pass   = go && !host_we && r_ok;
        d.err    = q.err || (go && !host_we && !r_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign host_rdata  = q.pass ? otp_rdata : '0;
    assign host_rvalid = q.rvalid;
    assign acc_err     = q.err;

endmodule

// File: rtl/lcm_key_gate.sv
module lcm_key_gate #(
    parameter int WORD_W    = 32,
    parameter int KEY_WORDS = 8,
    parameter int NUM_KEYS  = 6,
    parameter int CHIP_KEYS = 4,
    parameter int STRIDE_LG = 4,
    parameter logic [WORD_W*KEY_WORDS-1:0] FIXED_KEY = {KEY_WORDS{32'h6B1D_40C3}},
    localparam int ADDR_W    = $clog2(NUM_KEYS) + STRIDE_LG,
    localparam int NUM_SLOTS = NUM_KEYS + 1,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int WIX_W     = $clog2(KEY_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           lcs,
    input  logic                 sp_en,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [WORD_W-1:0]    host_wdata,
    output logic [WORD_W-1:0]    host_rdata,
    output logic                 host_rvalid,
    output logic                 host_ready,
    output logic                 acc_err,
    output logic [NUM_KEYS-1:0]  key_rd_ok,
    output logic [NUM_KEYS-1:0]  key_wr_ok,
    output logic                 otp_en,
    output logic                 otp_we,
    output logic [ADDR_W-1:0]    otp_addr,
    output logic [WORD_W-1:0]    otp_wdata,
    input  logic [WORD_W-1:0]    otp_rdata,
    output logic                 kmu_we,
    output logic [SLOT_W-1:0]    kmu_slot,
    output logic [WIX_W-1:0]     kmu_word,
    output logic [WORD_W-1:0]    kmu_data,
    output logic [NUM_SLOTS-1:0] slot_valid,
    output logic                 export_done
);
    logic              ex_en, hp_en, hp_we;
    logic [ADDR_W-1:0] ex_addr;

    lcm_perm_decode #(.NUM_KEYS(NUM_KEYS), .CHIP_KEYS(CHIP_KEYS)) perm_i (
        .lcs   (lcs),
        .sp_en (sp_en),
        .rd_ok (key_rd_ok),
        .wr_ok (key_wr_ok)
    );

    lcm_export_seq #(
        .WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS), .NUM_KEYS(NUM_KEYS),
        .STRIDE_LG(STRIDE_LG), .ADDR_W(ADDR_W), .FIXED_KEY(FIXED_KEY)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .otp_en     (ex_en),
        .otp_addr   (ex_addr),
        .otp_rdata  (otp_rdata),
        .kmu_we     (kmu_we),
        .kmu_slot   (kmu_slot),
        .kmu_word   (kmu_word),
        .kmu_data   (kmu_data),
        .slot_valid (slot_valid),
        .done       (export_done)
    );

    lcm_host_port #(
        .WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS), .NUM_KEYS(NUM_KEYS),
        .STRIDE_LG(STRIDE_LG), .ADDR_W(ADDR_W)
    ) host_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (export_done),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .rd_ok       (key_rd_ok),
        .wr_ok       (key_wr_ok),
        .otp_rdata   (otp_rdata),
        .otp_en      (hp_en),
        .otp_we      (hp_we),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .acc_err     (acc_err)
    );

    assign host_ready = export_done;
    assign otp_en     = export_done ? hp_en : ex_en;
    assign otp_we     = export_done && hp_we;
    assign otp_addr   = export_done ? host_addr : ex_addr;
    assign otp_wdata  = host_wdata;

endmodule

// File: rtl/lcm_key_gate_chk.sv
module lcm_key_gate_chk #(
    parameter int NUM_KEYS  = 6,
    parameter int STRIDE_LG = 4,
    parameter int ADDR_W    = 7,
    parameter int WORD_W    = 32,
    parameter int SLOT_W    = 3,
    parameter int WIX_W     = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            lcs,
    input logic                  sp_en,
    input logic                  acc_err,
    input logic [NUM_KEYS-1:0]   key_rd_ok,
    input logic [NUM_KEYS-1:0]   key_wr_ok,
    input logic                  otp_we,
    input logic [ADDR_W-1:0]     otp_addr,
    input logic                  kmu_we,
    input logic [SLOT_W-1:0]     kmu_slot,
    input logic [WIX_W-1:0]      kmu_word,
    input logic [NUM_KEYS:0]     slot_valid,
    input logic                  export_done
);
    logic                wr_allowed;
    int                  widx;

    always_comb begin
        widx       = int'(otp_addr >> STRIDE_LG);
        wr_allowed = 1'b0;
        for (int k = 0; k < NUM_KEYS; k++) begin
            if (widx == k) wr_allowed = key_wr_ok[k];
        end
    end

    AST_RETURN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (lcs == 2'd3) |-> (key_rd_ok == '0) && (&key_wr_ok)); // R3
    AST_SECURED_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (lcs == 2'd2) |-> (key_rd_ok == '0) && (key_wr_ok == '0)); // R4
    AST_NO_SP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_en |-> (key_rd_ok == '0)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> acc_err); // R5
    AST_WRITE_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        otp_we |-> wr_allowed); // R6
    AST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (kmu_we && kmu_word != '0) |-> ($past(kmu_we) && kmu_word == $past(kmu_word) + 1'b1
                                         && kmu_slot == $past(kmu_slot))); // R7
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        kmu_we |-> (int'(kmu_slot) <= NUM_KEYS)); // R7
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        export_done |=> export_done && $stable(slot_valid)); // R9
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        export_done |-> !kmu_we); // R9
    AST_NO_WRITE_IN_EXPORT: assert property (@(posedge clk) disable iff (!rst_n)
        !export_done |-> !otp_we); // R9

endmodule

bind lcm_key_gate lcm_key_gate_chk #(
    .NUM_KEYS(NUM_KEYS), .STRIDE_LG(STRIDE_LG), .ADDR_W(ADDR_W),
    .WORD_W(WORD_W), .SLOT_W(SLOT_W), .WIX_W(WIX_W)
) chk_i (.*);

// File: tb/lcm_key_gate_tb_top.sv
module lcm_key_gate_tb_top;
    localparam logic [255:0] TB_FIXED = 256'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0_13572468_9BDF0ACE_55AA33CC_DEADC0DE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lcs = 2'd0;
    logic        sp_en = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata, otp_wdata, kmu_data;
    logic [31:0] otp_rdata = '0;
    logic        host_rvalid, host_ready, acc_err, otp_en, otp_we, kmu_we, export_done;
    logic [5:0]  key_rd_ok, key_wr_ok;
    logic [6:0]  otp_addr, slot_valid;
    logic [2:0]  kmu_slot, kmu_word;

    always #5 clk = ~clk;

    lcm_key_gate #(.FIXED_KEY(TB_FIXED)) dut_i (.*);

    logic [31:0] otp_mem [128];
    logic [31:0] shadow [128];

    always @(posedge clk) begin
        if (otp_en) begin
            if (otp_we) otp_mem[otp_addr] <= otp_wdata;
            else        otp_rdata <= otp_mem[otp_addr];
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [2:0]  log_slot [64];
    logic [2:0]  log_word [64];
    logic [31:0] log_data [64];
    int n_log = 0;

    always @(negedge clk) begin
        if (rst_n && kmu_we && n_log < 64) begin
            log_slot[n_log] <= kmu_slot;
            log_word[n_log] <= kmu_word;
            log_data[n_log] <= kmu_data;
            n_log <= n_log + 1;
        end
    end

    function automatic logic [31:0] kw(int k, int j);
        return 32'(k * 32'h0123_4567 ^ j * 32'h89AB_CDEF ^ 32'h3C5A_0F00);
    endfunction

    function automatic int zeros_of(int k);
        int z = 0;
        for (int j = 0; j < 8; j++) z += 32 - $countones(kw(k, j));
        return z;
    endfunction

    function automatic bit key_good(int k);
        return (k != 2) && (k != 5);
    endfunction

    function automatic logic [5:0] exp_rd(int l, bit s);
        logic [5:0] v = '0;
        for (int k = 0; k < 6; k++) v[k] = s && ((l == 0 && k < 4) || (l == 1 && k >= 4));
        return v;
    endfunction

    function automatic logic [5:0] exp_wr(int l, bit s);
        return exp_rd(l, s) | ((l == 3) ? 6'h3F : 6'h00);
    endfunction

    function automatic string perm_tag(int l, bit s);
        if (l == 0 && s) return "R1";
        if (l == 1 && s) return "R2";
        if (l == 3) return "R3";
        return "R4";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_op(bit we, logic [6:0] a, logic [31:0] dat);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = dat;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    initial begin
        for (int a = 0; a < 128; a++) otp_mem[a] = '0;
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 8; j++) otp_mem[k*16 + j] = kw(k, j);
            // upper bits of the count word must be ignored
            otp_mem[k*16 + 8] = 32'hABCD_0000 | 32'(key_good(k) ? zeros_of(k) : zeros_of(k) + 1);
        end
        for (int a = 0; a < 128; a++) shadow[a] = otp_mem[a];
    end

    initial begin
        int e;
        bit exp_err;
        repeat (3) @(negedge clk);
        // reset state
        check("R9 reset done", 32'(export_done), 0);
        check("R9 reset valid", 32'(slot_valid), 0);
        check("R5 reset err", 32'(acc_err), 0);
        check("R9 reset ready", 32'(host_ready), 0);
        rst_n = 1'b1;
        // R10: permissions during export
        for (int l = 0; l < 4; l++) begin
            for (int s = 0; s < 2; s++) begin
                @(negedge clk);
                lcs = 2'(l); sp_en = 1'(s);
                #1;
                check("R10 busy", 32'(export_done), 0);
                check("R10 rd", 32'(key_rd_ok), 32'(exp_rd(l, 1'(s))));
                check("R10 wr", 32'(key_wr_ok), 32'(exp_wr(l, 1'(s))));
            end
        end
        while (!export_done) @(negedge clk);
        @(negedge clk);
        // R7 / R8 export trace
        check("R8 write count", 32'(n_log), 32'(8 * 5));
        e = 0;
        for (int j = 0; j < 8; j++) begin
            check("R7 fixed slot", 32'(log_slot[e]), 0);
            check("R7 fixed word", 32'(log_word[e]), 32'(j));
            check("R7 fixed data", log_data[e], TB_FIXED[j*32 +: 32]);
            e++;
        end
        for (int k = 0; k < 6; k++) begin
            if (key_good(k)) begin
                for (int j = 0; j < 8; j++) begin
                    check("R8 slot", 32'(log_slot[e]), 32'(k + 1));
                    check("R7 word", 32'(log_word[e]), 32'(j));
                    check("R7 data", log_data[e], kw(k, j));
                    e++;
                end
            end
        end
        check("R9 slot_valid", 32'(slot_valid), 32'h37);
        check("R9 ready", 32'(host_ready), 1);
        // permission sweep with host access
        exp_err = 1'b0;
        for (int l = 0; l < 4; l++) begin
            for (int s = 1; s >= 0; s--) begin
                @(negedge clk);
                lcs = 2'(l); sp_en = 1'(s);
                #1;
                check(perm_tag(l, 1'(s)), 32'(key_rd_ok), 32'(exp_rd(l, 1'(s))));
                check(perm_tag(l, 1'(s)), 32'(key_wr_ok), 32'(exp_wr(l, 1'(s))));
                for (int k = 0; k < 6; k++) begin
                    logic [6:0] ra, wa;
                    logic [31:0] wv;
                    bit rok, wok;
                    rok = exp_rd(l, 1'(s))[k];
                    wok = exp_wr(l, 1'(s))[k];
                    ra = 7'(k*16 + 3 + l);
                    host_op(1'b0, ra, '0);
                    if (!rok) exp_err = 1'b1;
                    check("R5 rvalid", 32'(host_rvalid), 1);
                    check("R5 rdata", host_rdata, rok ? shadow[ra] : 32'h0);
                    check("R5 err", 32'(acc_err), 32'(exp_err));
                    wa = 7'(k*16 + 7);
                    wv = 32'h5A00_0000 | 32'(l << 12) | 32'(s << 8) | 32'(k);
                    host_op(1'b1, wa, wv);
                    if (wok) shadow[wa] = wv;
                    check("R6 store", otp_mem[wa], shadow[wa]);
                end
            end
        end
        // readback of a written word under chip-manufacture access
        lcs = 2'd0; sp_en = 1'b1;
        host_op(1'b0, 7'(16 + 7), '0);
        check("R6 readback", host_rdata, shadow[16 + 7]);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule